// File: doc/BRIEF.md
# Flash Write Protection Checker

This block decides whether a program or erase request aimed at a serial NOR flash array may go ahead. It holds the protection state: a three-bit block-protect size field, a status write-disable bit, a write-lock bit and a lock-down bit for each 64 KB sector, and the lock flag of the one-time-programmable area. It also takes the active-low write-protect pin as an input. The command front end gives it the operation code and the sector field of the target address, which are the upper address bits. One clock later the block returns a verdict and a cause code.

The block also guards updates to its own state. A status write is refused while the write-disable bit is set and the pin is held low. A lock write to a sector that is locked down is ignored. Clearing bit 0 of the OTP control byte locks the OTP area for good. Three layers feed each verdict, checked in a fixed priority: the protected range, then the sector locks, then the OTP lock, which applies only to OTP programming.

Top module: `wp_guard`

## Requirements
- R1: After reset, the block-protect field is 000, the write-disable bit is 0, every sector write-lock and lock-down bit is 0, the OTP area is unlocked, and no response is valid.
- R2: With block-protect value b, the protected sectors are the top n, where n = 0 for b = 0, n = 2^(b-1) for b = 1..5, and n = 16 for b = 6 or 7. A sector s is protected when s >= 16 - n. Program (op 0), subsector erase (op 1) and sector erase (op 2) aimed at a protected sector are denied with cause 1.
- R3: Ops 0, 1 and 2 aimed at a sector whose write-lock bit is set, and not in the protected range, are denied with cause 2. When both apply, cause 1 is reported.
- R4: Bulk erase (op 3) is denied with cause 1 if the block-protect field is non-zero. Otherwise it is denied with cause 2 if any sector write-lock is set. Otherwise it is allowed.
- R5: A status write loads both the block-protect field and the write-disable bit. It is refused, with both left unchanged, when the write-disable bit is 1 and the write-protect pin is low.
- R6: A lock write to sector s loads that sector's write-lock bit and its lock-down bit. Once the lock-down bit is 1, every later lock write to that sector is ignored, so neither bit changes.
- R7: A write to the OTP control byte with bit 0 equal to 0 sets the OTP lock. Nothing clears it afterwards. OTP program (op 4) is allowed while the area is unlocked and denied with cause 3 once it is locked.
- R8: Op codes 5, 6 and 7 are denied with cause 4.
- R9: A response is valid in the cycle after a request and only then. It is allowed exactly when its cause is 0, and allow is 0 whenever no response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wp_n_i | input | 1 | Write-protect pin, active low |
| sr_wr_i | input | 1 | Status write strobe |
| sr_bp_i | input | 3 | Block-protect value to write |
| sr_srwd_i | input | 1 | Write-disable bit to write |
| lk_wr_i | input | 1 | Lock write strobe |
| lk_sector_i | input | 4 | Sector addressed by the lock write |
| lk_wlock_i | input | 1 | Write-lock value to write |
| lk_down_i | input | 1 | Lock-down value to write |
| otp_wr_i | input | 1 | OTP control byte write strobe |
| otp_ctl_bit0_i | input | 1 | Bit 0 of the OTP control byte being written |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Operation: 0 program, 1 subsector erase, 2 sector erase, 3 bulk erase, 4 OTP program |
| req_sector_i | input | 4 | Sector field of the request address (address bits 19:16) |
| bp_o | output | 3 | Current block-protect field |
| srwd_o | output | 1 | Current write-disable bit |
| wlock_o | output | 16 | Sector write-lock bits, bit s for sector s |
| down_o | output | 16 | Sector lock-down bits |
| otp_locked_o | output | 1 | OTP area locked |
| resp_valid_o | output | 1 | Verdict valid |
| resp_allow_o | output | 1 | Request may proceed |
| resp_cause_o | output | 3 | 0 allowed, 1 protected range, 2 sector lock, 3 OTP locked, 4 bad op |

## Verification
The range decode is swept over all eight block-protect values, every sector and each of the three sector-scoped operations. This separates an off-by-one at the boundary of the protected range from a wrong doubling step or a missing clamp. A single write-lock is walked across all sixteen sectors, with bulk erase, the locked sector and its neighbour probed each time. This catches a wrong lock index and a missed OR-reduction. Overlapping range and lock cases pin the cause priority. Writes to locked-down sectors, status writes with the pin low and high, and OTP control writes with bit 0 set and then cleared show that each guard ignores exactly the writes it should.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;
  localparam int BP_W = 3;

  typedef enum logic [2:0] {
    OP_PROG       = 3'd0,
    OP_SUB_ERASE  = 3'd1,
    OP_SEC_ERASE  = 3'd2,
    OP_BULK_ERASE = 3'd3,
    OP_OTP_PROG   = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    CZ_NONE  = 3'd0,
    CZ_RANGE = 3'd1,
    CZ_LOCK  = 3'd2,
    CZ_OTP   = 3'd3,
    CZ_BADOP = 3'd4
  } cause_e;

  // Number of sectors, counted from the top, covered by a protect value.
  function automatic int range_span(input logic [BP_W-1:0] bp, input int nsec);
    int span;
    if (bp == '0) return 0;
    span = 1 << (int'(bp) - 1);
    if (span > nsec) span = nsec;
    return span;
  endfunction

  function automatic logic in_range(input logic [BP_W-1:0] bp, input int sec, input int nsec);
    return (sec >= nsec - range_span(bp, nsec));
  endfunction
endpackage

// File: rtl/wp_status_reg.sv
module wp_status_reg
  import wp_guard_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [BP_W-1:0] bp_in_i,
  input  logic            srwd_in_i,
  input  logic            wp_n_i,
  output logic [BP_W-1:0] bp_o,
  output logic            srwd_o,
  output logic            hw_locked_o
);
  logic [BP_W-1:0] bp_q;
  logic            srwd_q;
  logic            accept;

  assign hw_locked_o = srwd_q & ~wp_n_i;
  assign accept      = wr_i & ~hw_locked_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q   <= '0;
      srwd_q <= 1'b0;
    end else if (accept) begin
      bp_q   <= bp_in_i;
      srwd_q <= srwd_in_i;
    end
  end

  assign bp_o   = bp_q;
  assign srwd_o = srwd_q;
endmodule

// File: rtl/wp_sector_locks.sv
module wp_sector_locks #(
  parameter int NSEC  = 16,
  parameter int SEC_W = $clog2(NSEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic             wlock_in_i,
  input  logic             down_in_i,
  output logic [NSEC-1:0]  wlock_o,
  output logic [NSEC-1:0]  down_o
);
  logic [NSEC-1:0] wlock_q;
  logic [NSEC-1:0] down_q;
  logic [NSEC-1:0] sel;

  // One-hot select of the addressed sector, masked by its lock-down.
  for (genvar g = 0; g < NSEC; g++) begin : g_sel
    assign sel[g] = wr_i && (sec_i == SEC_W'(g)) && !down_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlock_q <= '0;
      down_q  <= '0;
    end else begin
      for (int s = 0; s < NSEC; s++) begin
        if (sel[s]) begin
          wlock_q[s] <= wlock_in_i;
          down_q[s]  <= down_in_i;
        end
      end
    end
  end

  assign wlock_o = wlock_q;
  assign down_o  = down_q;
endmodule

// File: rtl/wp_otp_lock.sv
module wp_otp_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic bit0_i,
  output logic locked_o
);
  logic locked_q;

  // Programming only clears bits, so the lock can only be set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              locked_q <= 1'b0;
    else if (wr_i && !bit0_i) locked_q <= 1'b1;
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/wp_decide.sv
module wp_decide
  import wp_guard_pkg::*;
#(
  parameter int NSEC  = 16,
  parameter int SEC_W = $clog2(NSEC)
) (
  input  logic [2:0]      op_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [BP_W-1:0] bp_i,
  input  logic [NSEC-1:0] wlock_i,
  input  logic            otp_locked_i,
  output cause_e          cause_o,
  output logic            range_hit_o,
  output logic            lock_hit_o
);
  logic [NSEC-1:0] range_mask;
  logic            any_range;
  logic            any_lock;

  for (genvar g = 0; g < NSEC; g++) begin : g_range
    assign range_mask[g] = in_range(bp_i, g, NSEC);
  end

  assign range_hit_o = range_mask[sec_i];
  assign lock_hit_o  = wlock_i[sec_i];
  assign any_range   = |range_mask;
  assign any_lock    = |wlock_i;

  always_comb begin
    case (op_i)
      OP_PROG, OP_SUB_ERASE, OP_SEC_ERASE:
        cause_o = range_hit_o ? CZ_RANGE : (lock_hit_o ? CZ_LOCK : CZ_NONE);
      OP_BULK_ERASE:
        cause_o = any_range ? CZ_RANGE : (any_lock ? CZ_LOCK : CZ_NONE);
      OP_OTP_PROG:
        cause_o = otp_locked_i ? CZ_OTP : CZ_NONE;
      default:
        cause_o = CZ_BADOP;
    endcase
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_guard_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int SEC_W       = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wp_n_i,
  input  logic                   sr_wr_i,
  input  logic [BP_W-1:0]        sr_bp_i,
  input  logic                   sr_srwd_i,
  input  logic                   lk_wr_i,
  input  logic [SEC_W-1:0]       lk_sector_i,
  input  logic                   lk_wlock_i,
  input  logic                   lk_down_i,
  input  logic                   otp_wr_i,
  input  logic                   otp_ctl_bit0_i,
  input  logic                   req_valid_i,
  input  logic [2:0]             req_op_i,
  input  logic [SEC_W-1:0]       req_sector_i,
  output logic [BP_W-1:0]        bp_o,
  output logic                   srwd_o,
  output logic [NUM_SECTORS-1:0] wlock_o,
  output logic [NUM_SECTORS-1:0] down_o,
  output logic                   otp_locked_o,
  output logic                   resp_valid_o,
  output logic                   resp_allow_o,
  output logic [2:0]             resp_cause_o
);
  logic   hw_locked_w;
  logic   range_hit_w;
  logic   lock_hit_w;
  cause_e cause_w;

  logic   resp_valid_q;
  logic   resp_allow_q;
  cause_e resp_cause_q;

  wp_status_reg u_status (
    .clk(clk), .rst_n(rst_n), .wr_i(sr_wr_i), .bp_in_i(sr_bp_i),
    .srwd_in_i(sr_srwd_i), .wp_n_i(wp_n_i), .bp_o(bp_o), .srwd_o(srwd_o),
    .hw_locked_o(hw_locked_w)
  );

  wp_sector_locks #(.NSEC(NUM_SECTORS), .SEC_W(SEC_W)) u_locks (
    .clk(clk), .rst_n(rst_n), .wr_i(lk_wr_i), .sec_i(lk_sector_i),
    .wlock_in_i(lk_wlock_i), .down_in_i(lk_down_i),
    .wlock_o(wlock_o), .down_o(down_o)
  );

  wp_otp_lock u_otp (
    .clk(clk), .rst_n(rst_n), .wr_i(otp_wr_i), .bit0_i(otp_ctl_bit0_i),
    .locked_o(otp_locked_o)
  );

  wp_decide #(.NSEC(NUM_SECTORS), .SEC_W(SEC_W)) u_decide (
    .op_i(req_op_i), .sec_i(req_sector_i), .bp_i(bp_o), .wlock_i(wlock_o),
    .otp_locked_i(otp_locked_o), .cause_o(cause_w),
    .range_hit_o(range_hit_w), .lock_hit_o(lock_hit_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      resp_allow_q <= 1'b0;
      resp_cause_q <= CZ_NONE;
    end else begin
      resp_valid_q <= req_valid_i;
      resp_allow_q <= req_valid_i && (cause_w == CZ_NONE);
      resp_cause_q <= req_valid_i ? cause_w : CZ_NONE;
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_allow_o = resp_allow_q;
  assign resp_cause_o = resp_cause_q;
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int NSEC = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wp_n_i,
  input logic            sr_wr_i,
  input logic            req_valid_i,
  input logic [2:0]      req_op_i,
  input logic [2:0]      bp_o,
  input logic            srwd_o,
  input logic [NSEC-1:0] wlock_o,
  input logic [NSEC-1:0] down_o,
  input logic            otp_locked_o,
  input logic            resp_valid_o,
  input logic            resp_allow_o,
  input logic [2:0]      resp_cause_o,
  input logic            range_hit,
  input logic            lock_hit
);
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> resp_valid_o); // R9
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !resp_valid_o); // R9
  AST_ALLOW_IFF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    resp_allow_o |-> (resp_valid_o && resp_cause_o == 3'd0)); // R9
  AST_RANGE_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_op_i <= 3'd2 && range_hit) |=> (!resp_allow_o && resp_cause_o == 3'd1)); // R2
  AST_LOCK_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_op_i <= 3'd2 && lock_hit) |=> !resp_allow_o); // R3
  AST_HW_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_i && srwd_o && !wp_n_i) |=> ($stable(bp_o) && $stable(srwd_o))); // R5
  AST_DOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((down_o & $past(down_o)) == $past(down_o))); // R6
  AST_DOWN_FREEZES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (((wlock_o ^ $past(wlock_o)) & $past(down_o)) == '0)); // R6
  AST_OTP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    otp_locked_o |=> otp_locked_o); // R7
endmodule

bind wp_guard wp_guard_chk #(.NSEC(NUM_SECTORS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n_i), .sr_wr_i(sr_wr_i),
  .req_valid_i(req_valid_i), .req_op_i(req_op_i), .bp_o(bp_o), .srwd_o(srwd_o),
  .wlock_o(wlock_o), .down_o(down_o), .otp_locked_o(otp_locked_o),
  .resp_valid_o(resp_valid_o), .resp_allow_o(resp_allow_o),
  .resp_cause_o(resp_cause_o), .range_hit(range_hit_w), .lock_hit(lock_hit_w)
);

// File: tb/wp_guard_test.sv
`timescale 1ns/1ps
module wp_guard_test;
  localparam int NSEC = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wp_n = 1'b1;
  logic        sr_wr = 1'b0, sr_srwd = 1'b0;
  logic [2:0]  sr_bp = '0;
  logic        lk_wr = 1'b0, lk_wlock = 1'b0, lk_down = 1'b0;
  logic [3:0]  lk_sector = '0;
  logic        otp_wr = 1'b0, otp_bit0 = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [3:0]  req_sector = '0;
  logic [2:0]  bp_o;
  logic        srwd_o, otp_locked_o, resp_valid_o, resp_allow_o;
  logic [15:0] wlock_o, down_o;
  logic [2:0]  resp_cause_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  wp_guard uut (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .sr_wr_i(sr_wr), .sr_bp_i(sr_bp),
    .sr_srwd_i(sr_srwd), .lk_wr_i(lk_wr), .lk_sector_i(lk_sector),
    .lk_wlock_i(lk_wlock), .lk_down_i(lk_down), .otp_wr_i(otp_wr),
    .otp_ctl_bit0_i(otp_bit0), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_sector_i(req_sector), .bp_o(bp_o), .srwd_o(srwd_o), .wlock_o(wlock_o),
    .down_o(down_o), .otp_locked_o(otp_locked_o), .resp_valid_o(resp_valid_o),
    .resp_allow_o(resp_allow_o), .resp_cause_o(resp_cause_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Sectors covered by a protect value, written as a lookup rather than a shift.
  function automatic int top_count(input int bp);
    case (bp)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 4;
      4: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic req(input int op, input int sec, input int exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_sector = 4'(sec);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " cause"}, int'(resp_cause_o), exp);
    chk({tag, " allow"}, int'(resp_allow_o), int'(exp == 0));
  endtask

  task automatic set_sr(input int bp, input bit wd);
    @(negedge clk);
    sr_wr = 1'b1; sr_bp = 3'(bp); sr_srwd = wd;
    @(negedge clk);
    sr_wr = 1'b0;
  endtask

  task automatic set_lock(input int sec, input bit wl, input bit dn);
    @(negedge clk);
    lk_wr = 1'b1; lk_sector = 4'(sec); lk_wlock = wl; lk_down = dn;
    @(negedge clk);
    lk_wr = 1'b0;
  endtask

  task automatic otp_write(input bit b0);
    @(negedge clk);
    otp_wr = 1'b1; otp_bit0 = b0;
    @(negedge clk);
    otp_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bp", int'(bp_o), 0);
    chk("R1 srwd", int'(srwd_o), 0);
    chk("R1 wlock", int'(wlock_o), 0);
    chk("R1 down", int'(down_o), 0);
    chk("R1 otp", int'(otp_locked_o), 0);
    chk("R1 resp_valid", int'(resp_valid_o), 0);

    // R2 full sweep of protect value x sector x sector-scoped op
    for (int bp = 0; bp < 8; bp++) begin
      set_sr(bp, 1'b0);
      chk("R5 bp load", int'(bp_o), bp);
      for (int s = 0; s < NSEC; s++) begin
        for (int op = 0; op < 3; op++) begin
          req(op, s, (s >= NSEC - top_count(bp)) ? 1 : 0, "R2 range");
        end
      end
      req(3, 0, (bp != 0) ? 1 : 0, "R4 bulk vs range");
    end

    // R3 / R4 walking lock
    set_sr(0, 1'b0);
    for (int s = 0; s < NSEC; s++) begin
      set_lock(s, 1'b1, 1'b0);
      chk("R6 lock load", int'(wlock_o), 1 << s);
      req(0, s, 2, "R3 locked sector");
      req(2, (s + 1) % NSEC, 0, "R3 neighbour");
      req(3, 0, 2, "R4 bulk vs lock");
      set_lock(s, 1'b0, 1'b0);
    end
    req(3, 0, 0, "R4 bulk clean");

    // R3 priority: range beats lock
    set_lock(15, 1'b1, 1'b0);
    set_sr(1, 1'b0);
    req(1, 15, 1, "R3 range priority");
    req(3, 0, 1, "R4 range priority");
    set_sr(0, 1'b0);
    req(1, 15, 2, "R3 lock only");
    set_lock(15, 1'b0, 1'b0);

    // R6 lock-down
    set_lock(5, 1'b1, 1'b1);
    chk("R6 down set", int'(down_o[5]), 1);
    set_lock(5, 1'b0, 1'b0);
    chk("R6 wlock frozen", int'(wlock_o[5]), 1);
    chk("R6 down frozen", int'(down_o[5]), 1);
    req(0, 5, 2, "R6 frozen lock denies");
    set_lock(6, 1'b0, 1'b1);
    set_lock(6, 1'b1, 1'b0);
    chk("R6 unlocked frozen", int'(wlock_o[6]), 0);
    req(0, 6, 0, "R6 frozen unlock allows");

    // R5 hardware-protected status writes
    set_sr(2, 1'b1);
    chk("R5 wd set", int'(srwd_o), 1);
    wp_n = 1'b0;
    set_sr(0, 1'b0);
    chk("R5 refused bp", int'(bp_o), 2);
    chk("R5 refused wd", int'(srwd_o), 1);
    wp_n = 1'b1;
    set_sr(0, 1'b0);
    chk("R5 pin high bp", int'(bp_o), 0);
    chk("R5 pin high wd", int'(srwd_o), 0);
    wp_n = 1'b0;
    set_sr(3, 1'b0);
    chk("R5 wd clear pin low", int'(bp_o), 3);
    wp_n = 1'b1;
    set_sr(0, 1'b0);

    // R7 OTP lock
    req(4, 9, 0, "R7 otp open");
    otp_write(1'b1);
    chk("R7 bit0 high keeps open", int'(otp_locked_o), 0);
    req(4, 0, 0, "R7 otp still open");
    otp_write(1'b0);
    chk("R7 locked", int'(otp_locked_o), 1);
    req(4, 3, 3, "R7 otp denied");
    otp_write(1'b1);
    chk("R7 permanent", int'(otp_locked_o), 1);

    // R8 bad op codes
    for (int op = 5; op < 8; op++) req(op, op, 4, "R8 bad op");

    // R9 idle response
    @(negedge clk);
    chk("R9 idle valid", int'(resp_valid_o), 0);
    chk("R9 idle allow", int'(resp_allow_o), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule